// File: doc/BRIEF.md
# Physical Address Region Router

This block sits between a requester and a set of memory-mapped targets on a physical address bus. It keeps a small table of address windows. Each window has an inclusive lower bound, an inclusive upper bound, a flag that chooses absolute or window-relative addressing, and the index of the target port that serves it. A request (load, store or 32-bit compare-and-swap) is steered within the same cycle to the first valid window that contains its address. The target sees the operation, access size, write data and compare value unchanged. It sees the address either as presented or reduced by the window base.

Software or boot logic fills the table through a configuration write port. Each write appends a window at the next free slot. Windows are searched from the oldest slot upward, so overlapping windows resolve in favour of the earlier one. A request that falls in no window reaches no target. It returns zero data and a failure status, and it raises a fault indication that carries the address.

Top module: `addr_region_router`

## Requirements
- R1: A window matches an address when the address is greater than or equal to its lower bound and less than or equal to its upper bound. Both bounds are inclusive, and the addresses one below the lower bound and one above the upper bound do not match.
- R2: When several valid windows contain the address, the window in the lowest table slot is used. Slots fill in the order the windows were written.
- R3: If a window's relative flag is set, `tgtAddr` equals the request address minus the window's lower bound. Otherwise `tgtAddr` equals the request address.
- R4: A load (op code 0) to an address that no window contains returns `rspRdata` of zero for every size code, drives `tgtSel` to zero, raises `fault`, and sets `faultAddr` to the request address.
- R5: A store (op code 1) or a compare-and-swap (op code 2) to an uncovered address returns `rspOk` low, raises `fault` and selects no target.
- R6: A covered compare-and-swap forwards `reqWdata` (the new value) on `tgtWdata` and `reqExpect` on `tgtExpect`. The selected target's `tgtRdata` (the value seen) and `tgtOk` (swap done) are returned on `rspRdata` and `rspOk`.
- R7: The operation code and size code pass to the target unchanged. Size codes 0, 1, 2 and 3 mean 8, 16, 32 and 64 bits.
- R8: `tgtSel` is one-hot for a covered valid request, with bit p set for the window's target port p. It is all zero when `reqValid` is low, and `fault` is low when `reqValid` is low.
- R9: A configuration write when all NUM_REGIONS slots are in use leaves the table unchanged, and `cfgReject` is high for exactly the one cycle after that write.
- R10: After reset the table is empty, so every valid request faults. `cfgReject` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Append a window this cycle |
| cfgStart | input | ADDR_W | Inclusive lower bound of new window |
| cfgEnd | input | ADDR_W | Inclusive upper bound of new window |
| cfgRemap | input | 1 | 1: target sees window-relative address |
| cfgPort | input | PORT_W | Target port index of new window |
| cfgReject | output | 1 | One-cycle pulse after a write to a full table |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 0 load, 1 store, 2 compare-and-swap |
| reqSize | input | 2 | 0: 8, 1: 16, 2: 32, 3: 64 bits |
| reqAddr | input | ADDR_W | Physical request address |
| reqWdata | input | DATA_W | Store data or swap new value |
| reqExpect | input | 32 | Swap compare value |
| rspRdata | output | DATA_W | Data returned by target, zero on fault |
| rspOk | output | 1 | Success status from target, zero on fault |
| fault | output | 1 | Request hit no window |
| faultAddr | output | ADDR_W | Address of the faulting request |
| tgtSel | output | NUM_PORTS | One-hot target select |
| tgtOp | output | 2 | Forwarded operation |
| tgtSize | output | 2 | Forwarded size |
| tgtAddr | output | ADDR_W | Forwarded (possibly relative) address |
| tgtWdata | output | DATA_W | Forwarded write data |
| tgtExpect | output | 32 | Forwarded compare value |
| tgtRdata | input | NUM_PORTS*DATA_W | Per-port returned data |
| tgtOk | input | NUM_PORTS | Per-port success status |

## Verification
The table is loaded with two overlapping windows, a window of a single address and a fourth window, and mixes absolute and relative addressing. Addresses are then driven at each bound and one step outside it. These patterns separate an exclusive-bound or off-by-one compare (R1) from a last-hit priority bug (R2), and a missing or reversed base subtraction from a wrong port index (R3). Uncovered loads in every size, and uncovered stores and swaps, show that faults return zeros and failure status (R4, R5). Covered swaps whose targets answer both success and failure show that results are routed back from the chosen port only (R6). A fifth configuration write checks that a full table rejects it and keeps its earlier contents (R9).

// File: rtl/addr_region_pkg.sv
package addr_region_pkg;
  localparam int SLOT_FIELD_W = 8;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_CAS   = 2'd2;

  // Strobes from the control to the table datapath.
  typedef struct packed {
    logic                    wrEn;
    logic [SLOT_FIELD_W-1:0] wrSlot;
  } cfgStrobe_t;
endpackage

// File: rtl/addr_region_ctrl.sv
module addr_region_ctrl
  import addr_region_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgValid,
  output cfgStrobe_t             strobe,
  output logic [NUM_REGIONS-1:0] validVec,
  output logic                   cfgReject
);
  logic [IDX_W:0] fillCnt;
  logic           tableFull;

  assign tableFull = (fillCnt == (IDX_W+1)'(NUM_REGIONS));

  always_comb begin
    strobe.wrEn   = cfgValid && !tableFull;
    strobe.wrSlot = SLOT_FIELD_W'(fillCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt   <= '0;
      validVec  <= '0;
      cfgReject <= 1'b0;
    end else begin
      cfgReject <= cfgValid && tableFull;
      if (strobe.wrEn) begin
        validVec[fillCnt[IDX_W-1:0]] <= 1'b1;
        fillCnt                      <= fillCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_region_datapath.sv
module addr_region_datapath
  import addr_region_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int NUM_REGIONS = 4,
  parameter int NUM_PORTS   = 4,
  localparam int IDX_W  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  cfgStrobe_t                  strobe,
  input  logic [NUM_REGIONS-1:0]      validVec,
  input  logic [ADDR_W-1:0]           cfgStart,
  input  logic [ADDR_W-1:0]           cfgEnd,
  input  logic                        cfgRemap,
  input  logic [PORT_W-1:0]           cfgPort,
  input  logic                        reqValid,
  input  logic [ADDR_W-1:0]           reqAddr,
  output logic [NUM_PORTS-1:0]        tgtSel,
  output logic [ADDR_W-1:0]           tgtAddr,
  input  logic [NUM_PORTS*DATA_W-1:0] tgtRdata,
  input  logic [NUM_PORTS-1:0]        tgtOk,
  output logic [DATA_W-1:0]           rspRdata,
  output logic                        rspOk,
  output logic                        fault,
  output logic [ADDR_W-1:0]           faultAddr
);
  logic [ADDR_W-1:0] lowBound  [NUM_REGIONS];
  logic [ADDR_W-1:0] highBound [NUM_REGIONS];
  logic              relFlag   [NUM_REGIONS];
  logic [PORT_W-1:0] portIdx   [NUM_REGIONS];

  logic [NUM_REGIONS-1:0] hitVec;
  logic                   anyHit;
  logic [IDX_W-1:0]       winIdx;

  // Table storage, one slot per window.
  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lowBound[i]  <= '0;
        highBound[i] <= '0;
        relFlag[i]   <= 1'b0;
        portIdx[i]   <= '0;
      end else if (strobe.wrEn && strobe.wrSlot == SLOT_FIELD_W'(i)) begin
        lowBound[i]  <= cfgStart;
        highBound[i] <= cfgEnd;
        relFlag[i]   <= cfgRemap;
        portIdx[i]   <= cfgPort;
      end
    end
    assign hitVec[i] = validVec[i] && (reqAddr >= lowBound[i]) && (reqAddr <= highBound[i]);
  end

  // Lowest slot wins.
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  assign tgtAddr   = relFlag[winIdx] ? (reqAddr - lowBound[winIdx]) : reqAddr;
  assign tgtSel    = (reqValid && anyHit) ? (NUM_PORTS'(1) << portIdx[winIdx]) : '0;
  assign fault     = reqValid && !anyHit;
  assign faultAddr = fault ? reqAddr : '0;

  // Return path from the selected port only.
  always_comb begin
    rspRdata = '0;
    rspOk    = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (tgtSel[p]) begin
        rspRdata = tgtRdata[p*DATA_W +: DATA_W];
        rspOk    = tgtOk[p];
      end
    end
  end
endmodule

// File: rtl/addr_region_router.sv
module addr_region_router
  import addr_region_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int NUM_REGIONS = 4,
  parameter int NUM_PORTS   = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgValid,
  input  logic [ADDR_W-1:0]           cfgStart,
  input  logic [ADDR_W-1:0]           cfgEnd,
  input  logic                        cfgRemap,
  input  logic [PORT_W-1:0]           cfgPort,
  output logic                        cfgReject,
  input  logic                        reqValid,
  input  logic [1:0]                  reqOp,
  input  logic [1:0]                  reqSize,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqWdata,
  input  logic [31:0]                 reqExpect,
  output logic [DATA_W-1:0]           rspRdata,
  output logic                        rspOk,
  output logic                        fault,
  output logic [ADDR_W-1:0]           faultAddr,
  output logic [NUM_PORTS-1:0]        tgtSel,
  output logic [1:0]                  tgtOp,
  output logic [1:0]                  tgtSize,
  output logic [ADDR_W-1:0]           tgtAddr,
  output logic [DATA_W-1:0]           tgtWdata,
  output logic [31:0]                 tgtExpect,
  input  logic [NUM_PORTS*DATA_W-1:0] tgtRdata,
  input  logic [NUM_PORTS-1:0]        tgtOk
);
  cfgStrobe_t             strobe;
  logic [NUM_REGIONS-1:0] validVec;

  addr_region_ctrl #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid),
    .strobe(strobe), .validVec(validVec), .cfgReject(cfgReject)
  );

  addr_region_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS), .NUM_PORTS(NUM_PORTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .validVec(validVec),
    .cfgStart(cfgStart), .cfgEnd(cfgEnd), .cfgRemap(cfgRemap), .cfgPort(cfgPort),
    .reqValid(reqValid), .reqAddr(reqAddr),
    .tgtSel(tgtSel), .tgtAddr(tgtAddr), .tgtRdata(tgtRdata), .tgtOk(tgtOk),
    .rspRdata(rspRdata), .rspOk(rspOk), .fault(fault), .faultAddr(faultAddr)
  );

  assign tgtOp     = reqOp;
  assign tgtSize   = reqSize;
  assign tgtWdata  = reqWdata;
  assign tgtExpect = reqExpect;
endmodule

// File: rtl/addr_region_router_chk.sv
module addr_region_router_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgValid,
  input logic                 cfgReject,
  input logic                 reqValid,
  input logic [1:0]           reqOp,
  input logic [1:0]           reqSize,
  input logic [ADDR_W-1:0]    reqAddr,
  input logic [DATA_W-1:0]    rspRdata,
  input logic                 rspOk,
  input logic                 fault,
  input logic [ADDR_W-1:0]    faultAddr,
  input logic [NUM_PORTS-1:0] tgtSel,
  input logic [1:0]           tgtOp,
  input logic [1:0]           tgtSize,
  input logic [ADDR_W-1:0]    tgtAddr
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tgtSel)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (tgtSel == '0 && !fault)); // R8
  AST_FAULT_NO_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (tgtSel == '0 && rspRdata == '0 && faultAddr == reqAddr)); // R4
  AST_FAULT_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !rspOk); // R5
  AST_SIZE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (tgtSel != '0) |-> (tgtSize == reqSize && tgtOp == reqOp)); // R7
  AST_REL_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    (tgtSel != '0) |-> (tgtAddr <= reqAddr)); // R3
  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    cfgReject |-> $past(cfgValid)); // R9
endmodule

bind addr_region_router addr_region_router_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgReject(cfgReject),
  .reqValid(reqValid), .reqOp(reqOp), .reqSize(reqSize), .reqAddr(reqAddr),
  .rspRdata(rspRdata), .rspOk(rspOk), .fault(fault), .faultAddr(faultAddr),
  .tgtSel(tgtSel), .tgtOp(tgtOp), .tgtSize(tgtSize), .tgtAddr(tgtAddr)
);

// File: tb/addr_region_router_test.sv
`timescale 1ns/100ps
module addr_region_router_test;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int NR = 4;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          cfgValid = 0;
  logic [AW-1:0] cfgStart = 0, cfgEnd = 0;
  logic          cfgRemap = 0;
  logic [1:0]    cfgPort = 0;
  logic          cfgReject;
  logic          reqValid = 0;
  logic [1:0]    reqOp = 0, reqSize = 0;
  logic [AW-1:0] reqAddr = 0;
  logic [DW-1:0] reqWdata = 0;
  logic [31:0]   reqExpect = 0;
  logic [DW-1:0] rspRdata;
  logic          rspOk, fault;
  logic [AW-1:0] faultAddr;
  logic [NP-1:0] tgtSel;
  logic [1:0]    tgtOp, tgtSize;
  logic [AW-1:0] tgtAddr;
  logic [DW-1:0] tgtWdata;
  logic [31:0]   tgtExpect;
  logic [NP*DW-1:0] tgtRdata;
  logic [NP-1:0] tgtOk;

  addr_region_router #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGIONS(NR), .NUM_PORTS(NP)) uut (.*);

  // Target models: data tags the port and echoes the address; ok is low when address bit 2 is set.
  for (genvar p = 0; p < NP; p++) begin : g_tgt
    assign tgtRdata[p*DW +: DW] = {8'hA0 + 8'(p), 24'h0, tgtAddr};
    assign tgtOk[p] = ~tgtAddr[2];
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench-side window model.
  logic [AW-1:0] mStart [NR];
  logic [AW-1:0] mEnd   [NR];
  logic          mRel   [NR];
  int            mPort  [NR];
  int            mCount = 0;

  typedef struct {
    string         tag;
    logic [NP-1:0] sel;
    logic [AW-1:0] addr;
    logic [1:0]    op, size;
    logic [DW-1:0] wdata;
    logic [31:0]   expv;
    logic [DW-1:0] rdata;
    logic          ok, flt;
    logic [AW-1:0] fAddr;
  } item_t;
  item_t sb[$];

  task automatic check(input string tag, input bit good, input string detail);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s", tag, detail);
    end
  endtask

  task automatic doCfg(input logic [AW-1:0] s, input logic [AW-1:0] e, input logic rel, input int port);
    bit full;
    full = (mCount == NR);
    @(posedge clk); #1;
    cfgValid = 1; cfgStart = s; cfgEnd = e; cfgRemap = rel; cfgPort = 2'(port);
    if (!full) begin
      mStart[mCount] = s; mEnd[mCount] = e; mRel[mCount] = rel; mPort[mCount] = port;
      mCount++;
    end
    @(posedge clk); #1;
    cfgValid = 0;
    @(negedge clk);
    check("R9", cfgReject == full, $sformatf("cfgReject actual %0b expected %0b", cfgReject, full));
    if (full) begin
      @(negedge clk);
      check("R9", cfgReject == 0, $sformatf("cfgReject second cycle actual %0b expected 0", cfgReject));
    end
  endtask

  task automatic doReq(input string tag, input logic [1:0] op, input logic [1:0] size,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic [31:0] ev);
    item_t it;
    int hit;
    hit = -1;
    for (int i = NR - 1; i >= 0; i--)
      if (i < mCount && a >= mStart[i] && a <= mEnd[i]) hit = i;
    it.tag = tag; it.op = op; it.size = size; it.wdata = wd; it.expv = ev;
    if (hit < 0) begin
      it.sel = '0; it.addr = 'x; it.rdata = '0; it.ok = 0; it.flt = 1; it.fAddr = a;
    end else begin
      it.sel   = NP'(1) << mPort[hit];
      it.addr  = mRel[hit] ? a - mStart[hit] : a;
      it.rdata = {8'hA0 + 8'(mPort[hit]), 24'h0, it.addr};
      it.ok    = ~it.addr[2];
      it.flt   = 0;
      it.fAddr = '0;
    end
    @(posedge clk); #1;
    reqValid = 1; reqOp = op; reqSize = size; reqAddr = a; reqWdata = wd; reqExpect = ev;
    sb.push_back(it);
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  // Monitor: compare design output against queued expectations.
  always @(negedge clk) begin
    if (reqValid) begin
      if (sb.size() == 0) begin
        check("monitor", 0, "result with no expectation");
      end else begin
        item_t e;
        bit good;
        e = sb.pop_front();
        good = (tgtSel == e.sel) && (fault == e.flt) && (rspRdata == e.rdata) && (rspOk == e.ok);
        if (e.flt) good = good && (faultAddr == e.fAddr);
        else good = good && (tgtAddr == e.addr) && (tgtOp == e.op) && (tgtSize == e.size)
                         && (tgtWdata == e.wdata) && (tgtExpect == e.expv);
        check(e.tag, good, $sformatf(
          "sel %b/%b addr %h/%h op %0d/%0d size %0d/%0d rdata %h/%h ok %b/%b fault %b/%b faddr %h/%h (actual/expected)",
          tgtSel, e.sel, tgtAddr, e.addr, tgtOp, e.op, tgtSize, e.size, rspRdata, e.rdata,
          rspOk, e.ok, fault, e.flt, faultAddr, e.fAddr));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check("R10", tgtSel == 0 && cfgReject == 0 && fault == 0,
          $sformatf("reset sel %b rej %b fault %b expected 0 0 0", tgtSel, cfgReject, fault));
    doReq("R10", 0, 2, 32'h0000_1000, 0, 0);

    doCfg(32'h1000, 32'h1FFF, 1, 2);
    doCfg(32'h1800, 32'h2FFF, 0, 1);
    doCfg(32'h8000, 32'h8000, 1, 0);
    doCfg(32'h3000, 32'h3FFF, 1, 3);
    doCfg(32'h9000, 32'h9FFF, 0, 0);   // R9: table full, ignored
    doReq("R9", 0, 3, 32'h0000_9000, 0, 0);

    doReq("R1", 0, 2, 32'h0000_1000, 0, 0);
    doReq("R1", 0, 2, 32'h0000_0FFF, 0, 0);
    doReq("R1", 1, 2, 32'h0000_2FFF, 64'h55, 0);
    doReq("R1", 0, 1, 32'h0000_3000, 0, 0);
    doReq("R1", 0, 1, 32'h0000_3FFF, 0, 0);
    doReq("R1", 0, 1, 32'h0000_4000, 0, 0);
    doReq("R2", 0, 2, 32'h0000_1800, 0, 0);
    doReq("R2", 0, 2, 32'h0000_1FFF, 0, 0);
    doReq("R2", 0, 2, 32'h0000_2000, 0, 0);
    doReq("R3", 0, 3, 32'h0000_8000, 0, 0);
    doReq("R3", 0, 3, 32'h0000_7FFF, 0, 0);
    doReq("R3", 0, 3, 32'h0000_2004, 0, 0);
    for (int s = 0; s < 4; s++) doReq("R4", 0, 2'(s), 32'h0000_5000 + 32'(s), 0, 0);
    doReq("R5", 1, 3, 32'h0000_6000, 64'hDEAD_BEEF_0000_1111, 0);
    doReq("R5", 2, 2, 32'h0000_7000, 64'h1234, 32'h5678);
    doReq("R6", 2, 2, 32'h0000_1004, 64'h0000_0000_CAFE_0001, 32'h0BAD_F00D);
    doReq("R6", 2, 2, 32'h0000_3008, 64'h0000_0000_CAFE_0002, 32'h1111_2222);
    for (int s = 0; s < 4; s++) doReq("R7", 1, 2'(s), 32'h0000_2000, 64'h0102_0304_0506_0708, 0);
    doReq("R8", 2, 1, 32'h0000_3010, 64'h9, 32'h7);

    repeat (3) @(posedge clk);
    check("monitor", sb.size() == 0, $sformatf("pending items actual %0d expected 0", sb.size()));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule